// File: doc/BRIEF.md
# Snooping Three-State Line Coherence Controller

This block keeps the coherence state of the lines held in one private cache that sits on a shared, ordered broadcast bus. Every line is Invalid, Shared (a read-only copy that other caches may also hold) or Modified (the only valid copy, writable). The local core sends read and write requests. The controller serves hits at once. For a miss it raises a bus request, and for a miss that must evict a dirty line it first raises a write-back. It watches read and read-exclusive transactions from other caches, and it downgrades or invalidates its own copies in response. When one of those transactions reaches a line held Modified, it signals a flush.

Lines are direct-mapped. The low `IDX_W` bits of a line address choose the slot and the remaining bits are the tag. A lookup hits when the stored tag matches and the slot is not Invalid. The snoop inputs carry only transactions from other caches. When a snoop and a granted processor transaction update the same slot in the same cycle, the processor's update wins, because the snoop is taken as ordered before it. A write-back that is still waiting for its grant is dropped if a snoop removes the dirty state of the victim.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every slot is Invalid, `bus_req`, `cpu_stall` and `flush_valid` are low, and the first access to any slot misses.
- R2: A read that misses raises `bus_req` with `bus_cmd` = 2'b01 (read) and `bus_addr` = the request address. After the grant the line is Shared.
- R3: A read that hits a Shared or Modified line raises `cpu_done` in the same cycle as `cpu_valid`, with no bus request, and leaves the state unchanged.
- R4: A write to a line that is missing or Shared raises `bus_req` with `bus_cmd` = 2'b10 (read-exclusive) at the request address. After the grant the line is Modified.
- R5: A write that hits a Modified line completes in the same cycle with no bus request.
- R6: A miss whose slot holds a Modified line with another tag first requests `bus_cmd` = 2'b11 (write-back) at the victim's address. Once that is granted, it requests the fill command.
- R7: `bus_req`, `bus_cmd` and `bus_addr` hold steady until `bus_grant`. The state update and `cpu_done` occur in the grant cycle, and `cpu_stall` stays high until then.
- R8: A snooped read (`snoop_excl` = 0) that hits a Modified line raises `flush_valid` with `flush_addr` = the line address one cycle later, and the line becomes Shared.
- R9: A snooped read that hits a Shared line causes no flush and no state change.
- R10: A snooped read-exclusive (`snoop_excl` = 1) invalidates a Shared hit with no flush. On a Modified hit it flushes as in R8 and then invalidates.
- R11: A snoop to a slot that is Invalid, or that holds another tag, causes no flush and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Core request, held until `cpu_done` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address {tag, index} |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request pending, not complete this cycle |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 01 read, 10 read-exclusive, 11 write-back |
| bus_addr | output | ADDR_W | Line address of the bus request |
| bus_grant | input | 1 | Bus grant for the current request |
| snoop_valid | input | 1 | Transaction from another cache observed |
| snoop_excl | input | 1 | 1 = read-exclusive, 0 = read |
| snoop_addr | input | ADDR_W | Line address of the snooped transaction |
| flush_valid | output | 1 | A dirty line must be flushed |
| flush_addr | output | ADDR_W | Line address to flush |

## Verification
Hit results (`cpu_done` with `bus_req` low) are combinational, so they are due in the same cycle that `cpu_valid` is driven. The bench samples them one nanosecond after the driving falling edge. A bus request appears one rising edge after a miss is seen, and the fill request appears one edge after a write-back grant. The bench holds the grant back for a random 0 to 2 cycles and checks in every waiting cycle that the request is stable and `cpu_stall` is high, then checks `cpu_done` in the grant cycle itself. A flush is registered, so the bench checks `flush_valid` and `flush_addr` in the cycle after the edge that sampled the snoop. The state change from a snoop is checked through the bus behaviour of later accesses, which are compared against a bench-side model of tags and states.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_WB   = 2'd1,
        PS_REQ  = 2'd2
    } proc_st_e;

    // state a line takes when another cache's transaction hits it
    function automatic line_st_e snoop_next(line_st_e cur, logic excl);
        line_st_e nxt;
        case (cur)
            LS_M:    nxt = excl ? LS_I : LS_S;
            LS_S:    nxt = excl ? LS_I : LS_S;
            default: nxt = LS_I;
        endcase
        return nxt;
    endfunction

    // a hit line can serve the access without the bus
    function automatic logic served_locally(line_st_e cur, logic wr);
        return (cur == LS_M) || ((cur == LS_S) && !wr);
    endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic [TAG_W-1:0] cpu_tag_rd,
    output line_st_e         cpu_st_rd,
    input  logic             cpu_we,
    input  logic [TAG_W-1:0] cpu_tag_wr,
    input  line_st_e         cpu_st_wr,
    input  logic [IDX_W-1:0] snp_idx,
    output logic [TAG_W-1:0] snp_tag_rd,
    output line_st_e         snp_st_rd,
    input  logic             snp_we,
    input  line_st_e         snp_st_wr
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        line_st_e         st;
    } line_t;

    line_t lines_d [LINES];
    line_t lines_q [LINES];

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            lines_d[i] = lines_q[i];
        end
        if (snp_we) begin
            lines_d[snp_idx].st = snp_st_wr;
        end
        // the processor's granted update is ordered after the snoop
        if (cpu_we) begin
            lines_d[cpu_idx].tag = cpu_tag_wr;
            lines_d[cpu_idx].st  = cpu_st_wr;
        end
    end

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lines_q[g] <= '{tag: '0, st: LS_I};
                end else begin
                    lines_q[g] <= lines_d[g];
                end
            end
        end
    endgenerate

    assign cpu_tag_rd = lines_q[cpu_idx].tag;
    assign cpu_st_rd  = lines_q[cpu_idx].st;
    assign snp_tag_rd = lines_q[snp_idx].tag;
    assign snp_st_rd  = lines_q[snp_idx].st;

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   snp_valid,
    input  logic                   snp_excl,
    input  logic [IDX_W+TAG_W-1:0] snp_addr,
    output logic [IDX_W-1:0]       snp_idx,
    input  logic [TAG_W-1:0]       line_tag,
    input  line_st_e               line_st,
    output logic                   st_we,
    output line_st_e               st_new,
    output logic                   flush_valid,
    output logic [IDX_W+TAG_W-1:0] flush_addr
);
    localparam int ADDR_W = IDX_W + TAG_W;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } flush_t;

    flush_t           fl_d, fl_q;
    logic [TAG_W-1:0] snp_tag;
    logic             hit;

    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    always_comb begin
        hit    = snp_valid && (line_st != LS_I) && (line_tag == snp_tag);
        st_new = snoop_next(line_st, snp_excl);
        st_we  = hit && (st_new != line_st);
        fl_d.valid = hit && (line_st == LS_M);
        fl_d.addr  = fl_d.valid ? snp_addr : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flush_valid = fl_q.valid;
    assign flush_addr  = fl_q.addr;

endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_valid,
    input  logic                   cpu_write,
    input  logic [IDX_W+TAG_W-1:0] cpu_addr,
    output logic                   cpu_done,
    output logic [IDX_W-1:0]       rd_idx,
    input  logic [TAG_W-1:0]       line_tag,
    input  line_st_e               line_st,
    output logic                   upd_we,
    output logic [TAG_W-1:0]       upd_tag,
    output line_st_e               upd_st,
    output logic                   bus_req,
    output bus_cmd_e               bus_cmd,
    output logic [IDX_W+TAG_W-1:0] bus_addr,
    input  logic                   bus_grant
);
    localparam int ADDR_W = IDX_W + TAG_W;

    typedef struct packed {
        proc_st_e         ps;
        logic             wr;
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
    } fsm_t;

    fsm_t             s_d, s_q;
    logic [TAG_W-1:0] in_tag;
    logic [IDX_W-1:0] in_idx;
    logic             in_hit;

    assign in_idx = cpu_addr[IDX_W-1:0];
    assign in_tag = cpu_addr[ADDR_W-1:IDX_W];

    always_comb begin
        s_d      = s_q;
        cpu_done = 1'b0;
        upd_we   = 1'b0;
        upd_tag  = s_q.tag;
        upd_st   = LS_I;
        bus_req  = 1'b0;
        bus_cmd  = BC_NONE;
        bus_addr = '0;
        rd_idx   = (s_q.ps == PS_IDLE) ? in_idx : s_q.idx;
        in_hit   = (line_st != LS_I) && (line_tag == in_tag);

        case (s_q.ps)
            PS_IDLE: begin
                if (cpu_valid) begin
                    if (in_hit && served_locally(line_st, cpu_write)) begin
                        cpu_done = 1'b1;
                    end else begin
                        s_d.wr  = cpu_write;
                        s_d.tag = in_tag;
                        s_d.idx = in_idx;
                        s_d.ps  = (!in_hit && line_st == LS_M) ? PS_WB : PS_REQ;
                    end
                end
            end
            PS_WB: begin
                // the victim may have lost its dirty state to a snoop
                if (line_st == LS_M && line_tag != s_q.tag) begin
                    bus_req  = 1'b1;
                    bus_cmd  = BC_WB;
                    bus_addr = {line_tag, s_q.idx};
                    if (bus_grant) begin
                        upd_we  = 1'b1;
                        upd_tag = line_tag;
                        upd_st  = LS_I;
                        s_d.ps  = PS_REQ;
                    end
                end else begin
                    s_d.ps = PS_REQ;
                end
            end
            PS_REQ: begin
                bus_req  = 1'b1;
                bus_cmd  = s_q.wr ? BC_RDX : BC_RD;
                bus_addr = {s_q.tag, s_q.idx};
                if (bus_grant) begin
                    upd_we   = 1'b1;
                    upd_tag  = s_q.tag;
                    upd_st   = s_q.wr ? LS_M : LS_S;
                    cpu_done = 1'b1;
                    s_d.ps   = PS_IDLE;
                end
            end
            default: s_d.ps = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ps: PS_IDLE, wr: 1'b0, tag: '0, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic              cpu_stall,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_grant,
    input  logic              snoop_valid,
    input  logic              snoop_excl,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              flush_valid,
    output logic [ADDR_W-1:0] flush_addr
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag_rd, snp_tag_rd, upd_tag;
    line_st_e         cpu_st_rd, snp_st_rd, upd_st, snp_st_new;
    logic             upd_we, snp_we;
    bus_cmd_e         cmd;

    msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_idx    (cpu_idx),
        .cpu_tag_rd (cpu_tag_rd),
        .cpu_st_rd  (cpu_st_rd),
        .cpu_we     (upd_we),
        .cpu_tag_wr (upd_tag),
        .cpu_st_wr  (upd_st),
        .snp_idx    (snp_idx),
        .snp_tag_rd (snp_tag_rd),
        .snp_st_rd  (snp_st_rd),
        .snp_we     (snp_we),
        .snp_st_wr  (snp_st_new)
    );

    msi_req_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) req_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_write (cpu_write),
        .cpu_addr  (cpu_addr),
        .cpu_done  (cpu_done),
        .rd_idx    (cpu_idx),
        .line_tag  (cpu_tag_rd),
        .line_st   (cpu_st_rd),
        .upd_we    (upd_we),
        .upd_tag   (upd_tag),
        .upd_st    (upd_st),
        .bus_req   (bus_req),
        .bus_cmd   (cmd),
        .bus_addr  (bus_addr),
        .bus_grant (bus_grant)
    );

    msi_snoop_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W)) snoop_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_valid   (snoop_valid),
        .snp_excl    (snoop_excl),
        .snp_addr    (snoop_addr),
        .snp_idx     (snp_idx),
        .line_tag    (snp_tag_rd),
        .line_st     (snp_st_rd),
        .st_we       (snp_we),
        .st_new      (snp_st_new),
        .flush_valid (flush_valid),
        .flush_addr  (flush_addr)
    );

    assign bus_cmd   = cmd;
    assign cpu_stall = cpu_valid && !cpu_done;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_done,
    input logic              cpu_stall,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_grant,
    input logic              snoop_valid,
    input logic              flush_valid
);
    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant && !snoop_valid) |=>
            (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R7
    stall_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant) |-> (cpu_stall && !cpu_done));

    // R6
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_grant && bus_cmd == 2'b11) |=> (bus_req && bus_cmd != 2'b11));

    // R2
    req_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != 2'b00));

    // R8
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(snoop_valid));

    // R3
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> cpu_valid);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_valid   (cpu_valid),
    .cpu_done    (cpu_done),
    .cpu_stall   (cpu_stall),
    .bus_req     (bus_req),
    .bus_cmd     (bus_cmd),
    .bus_addr    (bus_addr),
    .bus_grant   (bus_grant),
    .snoop_valid (snoop_valid),
    .flush_valid (flush_valid)
);

// File: tb/msi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_tb_top;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 3;
    localparam int LINES  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_done, cpu_stall, bus_req;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_grant = 1'b0;
    logic              snoop_valid = 1'b0, snoop_excl = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic              flush_valid;
    logic [ADDR_W-1:0] flush_addr;

    int checks = 0;
    int bad = 0;
    int cycles = 0;
    int mst [LINES];
    int mtag [LINES];
    logic [31:0] seed_v;

    always #2.5 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_done(cpu_done), .cpu_stall(cpu_stall),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_grant(bus_grant), .snoop_valid(snoop_valid), .snoop_excl(snoop_excl),
        .snoop_addr(snoop_addr), .flush_valid(flush_valid), .flush_addr(flush_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [ADDR_W-1:0] a);
        return int'(a[IDX_W-1:0]);
    endfunction

    function automatic int tag_of(input logic [ADDR_W-1:0] a);
        return int'(a[ADDR_W-1:IDX_W]);
    endfunction

    // 1 = Shared, 2 = Modified: served without the bus
    function automatic bit local_ok(input int st, input bit hit, input bit wr);
        return hit && (st == 2 || (st == 1 && !wr));
    endfunction

    task automatic wait_grant(input logic [1:0] ecmd, input logic [ADDR_W-1:0] eaddr,
                              input string req, input bit fill);
        int w;
        w = int'($urandom_range(0, 2));
        @(negedge clk); #1;
        chk(bus_req && bus_cmd == ecmd && bus_addr == eaddr, req,
            {bus_req, bus_cmd, bus_addr}, {1'b1, ecmd, eaddr});
        for (int k = 0; k < w; k++) begin
            @(posedge clk); @(negedge clk); #1;
            // R7 request held and core stalled while waiting
            chk(bus_req && bus_cmd == ecmd && bus_addr == eaddr && cpu_stall && !cpu_done,
                "R7", {bus_req, bus_cmd, cpu_stall, cpu_done}, {1'b1, ecmd, 2'b10});
        end
        bus_grant = 1'b1;
        #0.5;
        // R7 completion in the grant cycle only for the fill
        chk(cpu_done == fill && cpu_stall == !fill, "R7", {cpu_done, cpu_stall}, {fill, !fill});
        @(posedge clk); #1;
        bus_grant = 1'b0;
    endtask

    task automatic cpu_op(input bit wr, input logic [ADDR_W-1:0] a);
        int i, t, cur;
        bit hit;
        i = idx_of(a); t = tag_of(a); cur = mst[i];
        hit = (cur != 0) && (mtag[i] == t);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a;
        #1;
        if (local_ok(cur, hit, wr)) begin
            chk(cpu_done && !bus_req && !cpu_stall, wr ? "R5" : "R3",
                {cpu_done, bus_req, cpu_stall}, 3'b100);
            @(posedge clk); #1;
            cpu_valid = 1'b0;
        end else begin
            chk(!cpu_done && cpu_stall && !bus_req, "R7", {cpu_done, cpu_stall, bus_req}, 3'b010);
            @(posedge clk);
            if (!hit && cur == 2) begin
                wait_grant(2'b11, {mtag[i][ADDR_W-IDX_W-1:0], a[IDX_W-1:0]}, "R6", 1'b0);
                mst[i] = 0;
            end
            wait_grant(wr ? 2'b10 : 2'b01, a, wr ? "R4" : "R2", 1'b1);
            cpu_valid = 1'b0;
            mtag[i] = t;
            mst[i] = wr ? 2 : 1;
        end
    endtask

    task automatic snoop_op(input bit excl, input logic [ADDR_W-1:0] a);
        int i, cur;
        bit hit, efl;
        string req;
        i = idx_of(a); cur = mst[i];
        hit = (cur != 0) && (mtag[i] == tag_of(a));
        efl = hit && cur == 2;
        if (!hit) req = "R11";
        else if (excl) req = "R10";
        else req = (cur == 2) ? "R8" : "R9";
        @(negedge clk);
        snoop_valid = 1'b1; snoop_excl = excl; snoop_addr = a;
        @(posedge clk); #1;
        snoop_valid = 1'b0;
        chk(flush_valid == efl && (!efl || flush_addr == a), req,
            {flush_valid, flush_addr}, {efl, efl ? a : flush_addr});
        if (hit) mst[i] = excl ? 0 : ((cur == 2) ? 1 : cur);
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int t, input int i);
        return ADDR_W'((t << IDX_W) | i);
    endfunction

    initial begin
        for (int i = 0; i < LINES; i++) begin
            mst[i] = 0; mtag[i] = 0;
        end
        seed_v = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 quiet outputs after reset
        chk(!bus_req && !cpu_stall && !flush_valid, "R1",
            {bus_req, cpu_stall, flush_valid}, 3'b000);
        for (int i = 0; i < LINES; i++) begin
            @(negedge clk);
            cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = mk(0, i);
            #1;
            // R1 every slot starts Invalid, so tag 0 still misses
            chk(cpu_stall && !cpu_done, "R1", {cpu_stall, cpu_done}, 2'b10);
            cpu_valid = 1'b0;
        end
        // directed corner cases
        cpu_op(0, mk(1, 1));   // R2 read miss
        cpu_op(0, mk(1, 1));   // R3 read hit Shared
        cpu_op(1, mk(1, 1));   // R4 upgrade
        cpu_op(1, mk(1, 1));   // R5 write hit Modified
        cpu_op(0, mk(1, 1));   // R3 read hit Modified
        snoop_op(0, mk(1, 1)); // R8 flush, to Shared
        snoop_op(0, mk(1, 1)); // R9 no flush
        cpu_op(0, mk(1, 1));   // R3 still Shared
        snoop_op(1, mk(1, 1)); // R10 Shared invalidated
        snoop_op(0, mk(1, 1)); // R11 line Invalid
        cpu_op(1, mk(1, 1));   // R4 write miss
        snoop_op(1, mk(2, 1)); // R11 other tag
        cpu_op(0, mk(2, 1));   // R6 write-back then read
        cpu_op(1, mk(3, 2));
        snoop_op(1, mk(3, 2)); // R10 Modified flushed, invalidated
        cpu_op(0, mk(3, 2));   // R2 miss again
        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [ADDR_W-1:0] a;
            int kind;
            a = mk(int'($urandom_range(0, 3)), int'($urandom_range(0, LINES - 1)));
            kind = int'($urandom_range(0, 3));
            if (kind < 2) cpu_op(kind[0], a);
            else snoop_op(kind[0], a);
        end
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule